// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Interrupt Detection

This block controls a bank of general-purpose pins from a 32-bit word bus. Software sets the output value and the output-enable of every pin. It sets and clears individual bits through write-only alias addresses, so no read-modify-write is needed. Each pin has its own configuration word. That word selects how the pin drives the pad: push-pull or open-drain. It selects where the driven value comes from: the output register or a shared pulse-density bit. It selects what the synchronised pad input must do to raise an interrupt, and whether that interrupt also requests a wake-up.

Interrupt causes collect in a sticky status register. The status register is written directly, ORed through a set alias or masked off through a clear alias. The block gives one combined interrupt line and one wake-up request line, both registered. Pad output and pad output-enable are registered as well. Read data comes back one cycle after the read strobe.

Byte addresses (word aligned):

| Address | Register | Access |
|---|---|---|
| 0x00 | OUT | read/write |
| 0x04 | OUT set alias | write only |
| 0x08 | OUT clear alias | write only |
| 0x0C | OE | read/write |
| 0x10 | OE set alias | write only |
| 0x14 | OE clear alias | write only |
| 0x18 | IN | read only |
| 0x1C | STATUS | read/write |
| 0x20 | STATUS set alias | write only |
| 0x24 | STATUS clear alias | write only |
| 0x28 + 4·n | CFG of pin n | read/write |

Fields of a pin configuration word:

| Bits | Field | Meaning |
|---|---|---|
| 0 | pulse source | 1 takes the pin's value from `pwm_bit`, 0 from OUT |
| 2 | drive | 1 push-pull, 0 open-drain |
| 9:7 | trigger | 0 none, 1 rising edge, 2 falling edge, 3 either edge, 4 level low, 5 level high, 6 and 7 none |
| 10 | wake | the pin's status bit also drives `wake` |

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, `pad_out`, `pad_oe`, `irq`, `wake` and `bus_rdata` are zero. OUT, OE, STATUS and every CFG word read zero.
- R2: A write to OUT (0x00) or OE (0x0C) loads the low pin-count bits of the data. Higher data bits are dropped and read back as zero. A write to the set alias (0x04, 0x10) ORs the data into the register. A write to the clear alias (0x08, 0x14) clears the bits that are 1 in the data.
- R3: A read of any alias address (0x04, 0x08, 0x10, 0x14, 0x20, 0x24) returns zero. A read returns its data on `bus_rdata` one cycle after the read strobe.
- R4: When CFG bit 2 = 1 (push-pull), `pad_out` of the pin equals its source value and `pad_oe` equals its OE bit. Both are valid one cycle after the register write.
- R5: When CFG bit 2 = 0 (open-drain), `pad_out` is 0 and `pad_oe` is the OE bit ANDed with the inverted source value. A source of 1 therefore releases the pad.
- R6: When CFG bit 0 = 1, the pin's source value is `pwm_bit` instead of its OUT bit.
- R7: IN (0x18) reads the pin's source value where OE is 1. Where OE is 0 it reads the pad input after a two-flop synchroniser.
- R8: Trigger codes 1, 2 and 3 (CFG bits 9:7) set the pin's STATUS bit once for each rising, falling or either edge of the synchronised input. Codes 0, 6 and 7 never set it.
- R9: Trigger codes 4 and 5 set the STATUS bit on every cycle in which the synchronised input is low (4) or high (5). A clear does not remove the bit while the level persists.
- R10: A write to STATUS (0x1C) loads it. The set alias (0x20) ORs into it and the clear alias (0x24) clears masked bits. A trigger event in the same cycle as a clearing write leaves the bit set.
- R11: `irq` is the OR of all STATUS bits, delayed by one register.
- R12: `wake` is the OR of the STATUS bits whose CFG bit 10 is 1, delayed by one register.
- R13: A CFG word keeps only bits 0, 2, 7 to 9 and 10. Every other bit reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | NPINS | Asynchronous pad inputs |
| pwm_bit | input | 1 | Shared pulse-density source bit |
| pad_out | output | NPINS | Pad output level |
| pad_oe | output | NPINS | Pad output enable |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
A wrong edge-history or trigger decode shows up four clocks after a pad transition. It appears as a STATUS bit that is missing, set on the wrong edge, or set twice for one edge. The bench sweeps every pin against every edge trigger code to expose it. A broken priority between a clearing write and a live level condition appears on the next STATUS read as a bit that stays cleared. A wrong drive-mode or source select appears on `pad_out`/`pad_oe` one clock after the configuring write. IN readback compares the drive path with the synchroniser path on mixed enable patterns.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  // word offsets on the bus (byte addresses)
  localparam int OFS_OUT     = 'h00;
  localparam int OFS_OUT_SET = 'h04;
  localparam int OFS_OUT_CLR = 'h08;
  localparam int OFS_OE      = 'h0C;
  localparam int OFS_OE_SET  = 'h10;
  localparam int OFS_OE_CLR  = 'h14;
  localparam int OFS_IN      = 'h18;
  localparam int OFS_ST      = 'h1C;
  localparam int OFS_ST_SET  = 'h20;
  localparam int OFS_ST_CLR  = 'h24;
  localparam int OFS_CFG     = 'h28;

  // configuration word field positions
  localparam int CFG_SRC_BIT  = 0;
  localparam int CFG_PP_BIT   = 2;
  localparam int CFG_TRIG_LSB = 7;
  localparam int CFG_WAKE_BIT = 10;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_BOTH = 3'd3,
    TRIG_LOW  = 3'd4,
    TRIG_HIGH = 3'd5
  } trig_e;

  typedef struct packed {
    logic  wake;
    trig_e trig;
    logic  push_pull;
    logic  use_pwm;
  } pin_cfg_t;

  function automatic pin_cfg_t cfg_from_word(logic [31:0] w);
    pin_cfg_t c;
    c.use_pwm   = w[CFG_SRC_BIT];
    c.push_pull = w[CFG_PP_BIT];
    c.trig      = trig_e'(w[CFG_TRIG_LSB +: 3]);
    c.wake      = w[CFG_WAKE_BIT];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(pin_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[CFG_SRC_BIT]        = c.use_pwm;
    w[CFG_PP_BIT]         = c.push_pull;
    w[CFG_TRIG_LSB +: 3]  = c.trig;
    w[CFG_WAKE_BIT]       = c.wake;
    return w;
  endfunction

endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [NPINS-1:0]      out_q,
  output logic [NPINS-1:0]      oe_q,
  output pin_cfg_t [NPINS-1:0]  cfg_q,
  output logic                  st_load,
  output logic                  st_set,
  output logic                  st_clr,
  output logic [NPINS-1:0]      wmask
);

  localparam logic [ADDR_W-1:0] A_OUT     = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'(OFS_OUT_SET);
  localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'(OFS_OUT_CLR);
  localparam logic [ADDR_W-1:0] A_OE      = ADDR_W'(OFS_OE);
  localparam logic [ADDR_W-1:0] A_OE_SET  = ADDR_W'(OFS_OE_SET);
  localparam logic [ADDR_W-1:0] A_OE_CLR  = ADDR_W'(OFS_OE_CLR);
  localparam logic [ADDR_W-1:0] A_ST      = ADDR_W'(OFS_ST);
  localparam logic [ADDR_W-1:0] A_ST_SET  = ADDR_W'(OFS_ST_SET);
  localparam logic [ADDR_W-1:0] A_ST_CLR  = ADDR_W'(OFS_ST_CLR);

  assign wmask   = wdata[NPINS-1:0];
  assign st_load = wr_en && (addr == A_ST);
  assign st_set  = wr_en && (addr == A_ST_SET);
  assign st_clr  = wr_en && (addr == A_ST_CLR);

  // output value register with its two aliases
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (wr_en) begin
      if (addr == A_OUT)          out_q <= wmask;
      else if (addr == A_OUT_SET) out_q <= out_q | wmask;
      else if (addr == A_OUT_CLR) out_q <= out_q & ~wmask;
    end
  end

  // output enable register with its two aliases
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= '0;
    end else if (wr_en) begin
      if (addr == A_OE)          oe_q <= wmask;
      else if (addr == A_OE_SET) oe_q <= oe_q | wmask;
      else if (addr == A_OE_CLR) oe_q <= oe_q & ~wmask;
    end
  end

  // one configuration word per pin
  for (genvar i = 0; i < NPINS; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG + 4 * i);
    always_ff @(posedge clk) begin
      if (rst)                              cfg_q[i] <= '0;
      else if (wr_en && (addr == A_CFG))    cfg_q[i] <= cfg_from_word(wdata);
    end
  end

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] cur,
  output logic [NPINS-1:0] prev
);

  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign cur  = sync_q;
  assign prev = hist_q;

endmodule

// File: rtl/pinbank_trig.sv
module pinbank_trig
  import pinbank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pin_cfg_t [NPINS-1:0] cfg,
  input  logic [NPINS-1:0]     cur,
  input  logic [NPINS-1:0]     prev,
  input  logic                 st_load,
  input  logic                 st_set,
  input  logic                 st_clr,
  input  logic [NPINS-1:0]     wmask,
  output logic [NPINS-1:0]     status_q,
  output logic [NPINS-1:0]     wake_en,
  output logic                 irq_q,
  output logic                 wake_q
);

  logic [NPINS-1:0] event_w;
  logic [NPINS-1:0] st_nxt;

  for (genvar i = 0; i < NPINS; i++) begin : g_det
    always_comb begin
      unique case (cfg[i].trig)
        TRIG_RISE: event_w[i] = cur[i] & ~prev[i];
        TRIG_FALL: event_w[i] = ~cur[i] & prev[i];
        TRIG_BOTH: event_w[i] = cur[i] ^ prev[i];
        TRIG_LOW:  event_w[i] = ~cur[i];
        TRIG_HIGH: event_w[i] = cur[i];
        default:   event_w[i] = 1'b0;
      endcase
    end
    assign wake_en[i] = cfg[i].wake;
  end

  // software update first, hardware events ORed last so they win
  always_comb begin
    st_nxt = status_q;
    if (st_load)     st_nxt = wmask;
    else if (st_set) st_nxt = status_q | wmask;
    else if (st_clr) st_nxt = status_q & ~wmask;
    st_nxt = st_nxt | event_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      status_q <= st_nxt;
      irq_q    <= |status_q;
      wake_q   <= |(status_q & wake_en);
    end
  end

endmodule

// File: rtl/pinbank_pads.sv
module pinbank_pads
  import pinbank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pin_cfg_t [NPINS-1:0] cfg,
  input  logic [NPINS-1:0]     out_q,
  input  logic [NPINS-1:0]     oe_q,
  input  logic                 pwm_bit,
  input  logic [NPINS-1:0]     sync_in,
  output logic [NPINS-1:0]     in_view,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    logic src;
    assign src        = cfg[i].use_pwm ? pwm_bit : out_q[i];
    assign in_view[i] = oe_q[i] ? src : sync_in[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else if (cfg[i].push_pull) begin
        pad_out[i] <= src;
        pad_oe[i]  <= oe_q[i];
      end else begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= oe_q[i] & ~src;
      end
    end
  end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  input  logic              pwm_bit,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq,
  output logic              wake
);

  localparam int CFG_END = OFS_CFG + 4 * NPINS;

  logic [NPINS-1:0]     out_q;
  logic [NPINS-1:0]     oe_q;
  pin_cfg_t [NPINS-1:0] cfg_q;
  logic                 st_load, st_set, st_clr;
  logic [NPINS-1:0]     wmask;
  logic [NPINS-1:0]     sync_cur, sync_prev;
  logic [NPINS-1:0]     status_q;
  logic [NPINS-1:0]     wake_en;
  logic [NPINS-1:0]     in_view;
  logic [31:0]          rd_mux;

  initial begin
    if (NPINS < 1 || NPINS > 32) $error("NPINS must be 1..32");
    if (CFG_END > (1 << ADDR_W)) $error("ADDR_W too small for CFG words");
  end

  pinbank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .out_q(out_q), .oe_q(oe_q), .cfg_q(cfg_q),
    .st_load(st_load), .st_set(st_set), .st_clr(st_clr), .wmask(wmask)
  );

  pinbank_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .cur(sync_cur), .prev(sync_prev)
  );

  pinbank_trig #(.NPINS(NPINS)) u_trig (
    .clk(clk), .rst(rst), .cfg(cfg_q), .cur(sync_cur), .prev(sync_prev),
    .st_load(st_load), .st_set(st_set), .st_clr(st_clr), .wmask(wmask),
    .status_q(status_q), .wake_en(wake_en), .irq_q(irq), .wake_q(wake)
  );

  pinbank_pads #(.NPINS(NPINS)) u_pads (
    .clk(clk), .rst(rst), .cfg(cfg_q), .out_q(out_q), .oe_q(oe_q),
    .pwm_bit(pwm_bit), .sync_in(sync_cur), .in_view(in_view),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // read selection: aliases and unmapped words fall through to zero
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_OUT))     rd_mux[NPINS-1:0] = out_q;
    else if (bus_addr == ADDR_W'(OFS_OE)) rd_mux[NPINS-1:0] = oe_q;
    else if (bus_addr == ADDR_W'(OFS_IN)) rd_mux[NPINS-1:0] = in_view;
    else if (bus_addr == ADDR_W'(OFS_ST)) rd_mux[NPINS-1:0] = status_q;
    else begin
      for (int i = 0; i < NPINS; i++) begin
        if (bus_addr == ADDR_W'(OFS_CFG + 4 * i)) rd_mux = cfg_to_word(cfg_q[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
  import pinbank_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              wake,
  input logic [NPINS-1:0]  out_q,
  input logic [NPINS-1:0]  status_q,
  input logic [NPINS-1:0]  wake_en
);

  logic alias_rd;
  assign alias_rd = bus_rd && (bus_addr == ADDR_W'(OFS_OUT_SET) || bus_addr == ADDR_W'(OFS_OUT_CLR) ||
                               bus_addr == ADDR_W'(OFS_OE_SET)  || bus_addr == ADDR_W'(OFS_OE_CLR)  ||
                               bus_addr == ADDR_W'(OFS_ST_SET)  || bus_addr == ADDR_W'(OFS_ST_CLR));

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq && !wake && bus_rdata == '0)); // R1

  AST_OUT_SET_ORS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_OUT_SET)) |=>
      ((out_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))); // R2

  AST_OUT_CLR_MASKS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_OUT_CLR)) |=>
      ((out_q & $past(bus_wdata[NPINS-1:0])) == '0)); // R2

  AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    alias_rd |=> (bus_rdata == '0)); // R3

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
    (|status_q) |=> irq); // R11

  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
    !(|status_q) |=> !irq); // R11

  AST_WAKE_RISES: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & wake_en)) |=> wake); // R12

  AST_WAKE_FALLS: assert property (@(posedge clk) disable iff (rst)
    !(|(status_q & wake_en)) |=> !wake); // R12

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake),
  .out_q(out_q), .status_q(status_q), .wake_en(wake_en)
);

// File: tb/pinbank_ctrl_bench.sv
`timescale 1ns/1ps
module pinbank_ctrl_bench;

  localparam int NPINS  = 16;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NPINS-1:0]  pad_in = '0;
  logic              pwm_bit = 1'b0;
  logic [NPINS-1:0]  pad_out;
  logic [NPINS-1:0]  pad_oe;
  logic              irq;
  logic              wake;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pinbank_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_pinbank_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pwm_bit(pwm_bit),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .wake(wake)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int cfg_a(int p);
    return 'h28 + 4 * p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] exp_out, exp_oe, exp_st;
    logic [15:0] pats [4] = '{16'hA5A5, 16'h0FF0, 16'hFFFF, 16'h1234};

    settle(3);
    rst = 1'b0;
    settle(1);
    // R1 reset state
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 wake", 32'(wake), 0);
    chk("R1 rdata", bus_rdata, 0);
    rd('h00, d); chk("R1 OUT", d, 0);
    rd('h0C, d); chk("R1 OE", d, 0);
    rd('h1C, d); chk("R1 STATUS", d, 0);
    for (int p = 0; p < NPINS; p++) begin
      rd(cfg_a(p), d); chk("R1 CFG", d, 0);
    end

    // R2 direct write, set alias, clear alias
    wr('h00, 32'hFFFF_A5A5); rd('h00, d); chk("R2 OUT load", d, 32'h0000_A5A5);
    wr('h04, 32'h0000_0F00); rd('h00, d); chk("R2 OUT set", d, 32'h0000_AFA5);
    wr('h08, 32'h0000_0005); rd('h00, d); chk("R2 OUT clr", d, 32'h0000_AFA0);
    wr('h0C, 32'h0000_00F0); rd('h0C, d); chk("R2 OE load", d, 32'h0000_00F0);
    wr('h10, 32'h0000_8001); rd('h0C, d); chk("R2 OE set", d, 32'h0000_80F1);
    wr('h14, 32'h0000_00C0); rd('h0C, d); chk("R2 OE clr", d, 32'h0000_8031);

    // R3 alias reads return zero
    for (int k = 0; k < 6; k++) begin
      int al;
      al = (k < 2) ? 'h04 + 4 * k : (k < 4) ? 'h10 + 4 * (k - 2) : 'h20 + 4 * (k - 4);
      rd(al, d); chk("R3 alias read", d, 0);
    end

    // R4 push-pull drive, several patterns
    for (int p = 0; p < NPINS; p++) wr(cfg_a(p), 32'h4);
    for (int k = 0; k < 4; k++) begin
      exp_out = pats[k];
      exp_oe  = ~pats[(k + 1) % 4];
      wr('h00, 32'(exp_out));
      wr('h0C, 32'(exp_oe));
      settle(1);
      chk("R4 pad_out", 32'(pad_out), 32'(exp_out));
      chk("R4 pad_oe", 32'(pad_oe), 32'(exp_oe));
    end

    // R5 open-drain drive
    for (int p = 0; p < NPINS; p++) wr(cfg_a(p), 32'h0);
    for (int k = 0; k < 4; k++) begin
      exp_out = pats[k];
      exp_oe  = pats[(k + 2) % 4];
      wr('h00, 32'(exp_out));
      wr('h0C, 32'(exp_oe));
      settle(1);
      chk("R5 pad_out", 32'(pad_out), 0);
      chk("R5 pad_oe", 32'(pad_oe), 32'(exp_oe & ~exp_out));
    end

    // R6 pulse source select
    wr('h00, 32'h0);
    wr('h0C, 32'hFFFF);
    for (int p = 0; p < 8; p++) wr(cfg_a(p), 32'h5);   // push-pull, pulse source
    for (int p = 8; p < NPINS; p++) wr(cfg_a(p), 32'h1); // open-drain, pulse source
    for (int v = 0; v < 2; v++) begin
      pwm_bit = v[0];
      settle(2);
      chk("R6 pad_out", 32'(pad_out), v[0] ? 32'h00FF : 32'h0);
      chk("R6 pad_oe", 32'(pad_oe), v[0] ? 32'h00FF : 32'hFFFF);
    end
    pwm_bit = 1'b0;

    // R7 IN readback mixes driven value and synchronised pad
    for (int p = 0; p < NPINS; p++) wr(cfg_a(p), 32'h4);
    for (int k = 0; k < 4; k++) begin
      exp_out = pats[k];
      exp_oe  = pats[(k + 1) % 4];
      pad_in  = pats[(k + 3) % 4] ^ 16'h3C3C;
      wr('h00, 32'(exp_out));
      wr('h0C, 32'(exp_oe));
      settle(3);
      rd('h18, d);
      chk("R7 IN", d, 32'((exp_out & exp_oe) | (pad_in & ~exp_oe)));
    end

    // R8 edge trigger sweep over all pins and non-level codes
    for (int p = 0; p < NPINS; p++) wr(cfg_a(p), 32'h0);
    wr('h0C, 32'h0);
    pad_in = '0;
    settle(4);
    wr('h1C, 32'h0);
    for (int p = 0; p < NPINS; p++) begin
      for (int t = 0; t < 8; t++) begin
        if (t == 4 || t == 5) continue;
        wr(cfg_a(p), 32'(t) << 7);
        wr('h1C, 32'h0);
        @(negedge clk); pad_in[p] = 1'b1;
        settle(4);
        exp_st = (t == 1 || t == 3) ? 16'(1 << p) : 16'h0;
        rd('h1C, d); chk("R8 rise", d, 32'(exp_st));
        chk("R11 irq on edge", 32'(irq), 32'(exp_st != 0));
        wr('h1C, 32'h0);
        settle(4);
        rd('h1C, d); chk("R8 once per edge", d, 0);
        @(negedge clk); pad_in[p] = 1'b0;
        settle(4);
        exp_st = (t == 2 || t == 3) ? 16'(1 << p) : 16'h0;
        rd('h1C, d); chk("R8 fall", d, 32'(exp_st));
        wr(cfg_a(p), 32'h0);
        wr('h1C, 32'h0);
      end
    end

    // R9 level triggers persist through clears; R10 set wins over clear
    wr(cfg_a(3), 32'(4) << 7);
    settle(2);
    rd('h1C, d); chk("R9 low level", d, 32'h8);
    wr('h24, 32'h8);
    rd('h1C, d); chk("R10 event beats clear", d, 32'h8);
    @(negedge clk); pad_in[3] = 1'b1;
    settle(4);
    wr('h24, 32'h8);
    rd('h1C, d); chk("R9 low level released", d, 0);
    wr(cfg_a(3), 32'(5) << 7);
    settle(2);
    rd('h1C, d); chk("R9 high level", d, 32'h8);
    wr('h24, 32'h8);
    rd('h1C, d); chk("R9 high level persists", d, 32'h8);
    @(negedge clk); pad_in[3] = 1'b0;
    settle(4);
    wr('h24, 32'h8);
    rd('h1C, d); chk("R9 high level released", d, 0);
    wr(cfg_a(3), 32'h0);
    settle(2);

    // R10 status load, set, clear; R11 irq follows
    wr('h20, 32'h0A00); rd('h1C, d); chk("R10 set", d, 32'h0A00);
    chk("R11 irq high", 32'(irq), 1);
    wr('h1C, 32'h0800); rd('h1C, d); chk("R10 load", d, 32'h0800);
    wr('h24, 32'h0800); rd('h1C, d); chk("R10 clear", d, 0);
    settle(1);
    chk("R11 irq low", 32'(irq), 0);

    // R12 wake only through wake-enabled pins
    wr(cfg_a(5), 32'h400);
    wr('h20, 32'h20);
    settle(1);
    chk("R12 wake high", 32'(wake), 1);
    wr('h1C, 32'h40);
    settle(1);
    chk("R12 wake low", 32'(wake), 0);
    chk("R11 irq stays", 32'(irq), 1);
    wr('h1C, 32'h0);

    // R13 configuration word keeps only defined bits
    wr(cfg_a(7), 32'hFFFF_F87A);
    rd(cfg_a(7), d); chk("R13 cfg mask a", d, 32'h0000_0000 | (32'hFFFF_F87A & 32'h785));
    wr(cfg_a(7), 32'h0000_0000);
    wr(cfg_a(9), 32'hFFFF_FFFF);
    rd(cfg_a(9), d); chk("R13 cfg mask b", d, 32'h0000_0785);
    wr(cfg_a(9), 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule